// File: doc/BRIEF.md
# Twin-Port Burst RAM

This block is a synchronous memory that two independent masters share. Each side, called port A and port B, registers its address, write data and controls on the rising clock edge and can read or write any word in any cycle. Both sides may reach the same word in the same cycle. Words are 18 bits wide and split into two 9-bit lanes. Bits 8:0 form lane 0 and bits 17:9 form lane 1. Each lane has its own write enable on each port.

The address register of each port is also a burst counter. A load strobe copies the external address into it. A step input advances it by one, wrapping at the top of the port address range. A clear input forces it to zero. Each access uses the counter value produced at the capturing edge. A master can therefore issue one base address and then walk a block of words without driving addresses again. Each port selects its own read latency: flow-through presents data in the cycle after capture, and pipelined adds one output register. Two chip selects, one active-low and one active-high, let several instances be stacked in depth without decoding logic.

The storage accepts an access on every clock cycle, so the ports have no ready signal and apply no back-pressure. The read side carries a valid flag with its data, and the master must take the data in the cycle the flag is high. The port address is `ADDR_W` bits wide. Only the low `MEM_AW` bits select a word, which means a narrower array simply ignores the upper address bits.

Top module: `twin_port_burst_ram`

## Requirements
- R1: While `rst_n` is low and after its release, until a read is captured, both `rvalid` outputs are 0 and both `rdata` outputs are 0; both counters are 0 after reset.
- R2: At each edge a port's counter becomes 0 if `clr` is 1; otherwise the port address if the port is selected and `ld` is 1; otherwise counter+1 if selected and `inc` is 1; otherwise it keeps its value.
- R3: Stepping a counter that holds all ones (2^ADDR_W-1) gives 0.
- R4: A write stores wdata[8:0] only when lane_we[0] is 1 and wdata[17:9] only when lane_we[1] is 1; a lane whose enable is 0 keeps its old content.
- R5: A port is selected only when `cs_n` is 0 and `cs` is 1 at the edge. A port that is not selected writes nothing, ignores `ld` and `inc`, shows `rvalid`=0 with `rdata`=0 for that access, and still clears its counter on `clr`.
- R6: With `pipe`=0, a read captured at edge k shows `rvalid`=1 and its data after edge k. With `pipe`=1, the same read shows after edge k+1.
- R7: `rw`=1 selects a read and `rw`=0 a write. A write never raises `rvalid`. A read captured with `oe`=0 gives `rvalid`=0. Whenever `rvalid` is 0, `rdata` is 0.
- R8: When both ports write the same word in the same cycle, each lane that both enable takes port A's data, and a lane enabled by one port takes that port's data.
- R9: A read captured in the same cycle as the other port's write to the same word returns the word as it was before that write; an access captured one cycle later sees the new data.
- R10: Address bits at and above `MEM_AW` do not affect which word is accessed.
- R11: Both ports carry out independent reads and writes in the same cycles without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_a | input | 1 | Port A select, active low |
| cs_a | input | 1 | Port A select, active high |
| rw_a | input | 1 | Port A operation, 1 read, 0 write |
| lane_we_a | input | LANES | Port A per-lane write enables |
| oe_a | input | 1 | Port A read output enable |
| pipe_a | input | 1 | Port A latency, 1 pipelined, 0 flow-through |
| addr_a | input | ADDR_W | Port A external address |
| ld_a | input | 1 | Port A counter load strobe |
| inc_a | input | 1 | Port A counter step |
| clr_a | input | 1 | Port A counter clear |
| wdata_a | input | LANE_W*LANES | Port A write data |
| rvalid_a | output | 1 | Port A read data valid |
| rdata_a | output | LANE_W*LANES | Port A read data |
| cs_n_b | input | 1 | Port B select, active low |
| cs_b | input | 1 | Port B select, active high |
| rw_b | input | 1 | Port B operation, 1 read, 0 write |
| lane_we_b | input | LANES | Port B per-lane write enables |
| oe_b | input | 1 | Port B read output enable |
| pipe_b | input | 1 | Port B latency, 1 pipelined, 0 flow-through |
| addr_b | input | ADDR_W | Port B external address |
| ld_b | input | 1 | Port B counter load strobe |
| inc_b | input | 1 | Port B counter step |
| clr_b | input | 1 | Port B counter clear |
| wdata_b | input | LANE_W*LANES | Port B write data |
| rvalid_b | output | 1 | Port B read data valid |
| rdata_b | output | LANE_W*LANES | Port B read data |

## Verification
The functions that can land in the same cycle are a write on one port and a read or write on the other port to the same word. Directed steps provoke this by loading both counters with the same address in one cycle. They are run once with port A in flow-through mode and once with port B pipelined, and cover both same-lane and split-lane writes. The outcome is judged by reading the word back one cycle later and comparing it with port A's data, or with the merged lanes. The read captured in the colliding cycle must return the old contents. A long random phase then drives both ports over a handful of addresses, some with the ignored top bit set, so that collisions, clears, loads and latency changes interleave. Every cycle is compared against a behavioural model kept in the bench.

// File: rtl/tpbr_pkg.sv
package tpbr_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD,
    CNT_CLEAR,
    CNT_LOAD,
    CNT_STEP
  } cnt_op_e;

  // clear outranks load, load outranks step
  function automatic cnt_op_e pick_cnt_op(input logic clr, input logic load, input logic step);
    if (clr)  return CNT_CLEAR;
    if (load) return CNT_LOAD;
    if (step) return CNT_STEP;
    return CNT_HOLD;
  endfunction

endpackage

// File: rtl/tpbr_port_front.sv
module tpbr_port_front
  import tpbr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_in,
  input  logic                      rw,
  input  logic [LANES-1:0]          lane_we,
  input  logic                      oe,
  input  logic                      pipe,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      ld,
  input  logic                      inc,
  input  logic                      clr,
  input  logic [LANE_W*LANES-1:0]   wdata,
  output logic [ADDR_W-1:0]         cnt,
  output logic                      sel_q,
  output logic                      rd_q,
  output logic                      oe_q,
  output logic                      pipe_q,
  output logic [LANES-1:0]          we_q,
  output logic [LANE_W*LANES-1:0]   wdata_q
);

  cnt_op_e op;

  always_comb op = pick_cnt_op(clr, ld && sel_in, inc && sel_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sel_q   <= 1'b0;
      rd_q    <= 1'b0;
      oe_q    <= 1'b0;
      pipe_q  <= 1'b0;
      we_q    <= '0;
      wdata_q <= '0;
    end else begin
      unique case (op)
        CNT_CLEAR: cnt <= '0;
        CNT_LOAD:  cnt <= addr;
        CNT_STEP:  cnt <= cnt + 1'b1;
        default:   cnt <= cnt;
      endcase
      sel_q   <= sel_in;
      rd_q    <= rw;
      oe_q    <= oe;
      pipe_q  <= pipe;
      we_q    <= (sel_in && !rw) ? lane_we : '0;
      wdata_q <= wdata;
    end
  end

endmodule

// File: rtl/tpbr_array.sv
module tpbr_array #(
  parameter int ADDR_W = 8,
  parameter int MEM_AW = 7,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic [ADDR_W-1:0]        a_addr,
  input  logic [LANES-1:0]         a_we,
  input  logic [LANE_W*LANES-1:0]  a_wdata,
  input  logic [ADDR_W-1:0]        b_addr,
  input  logic [LANES-1:0]         b_we,
  input  logic [LANE_W*LANES-1:0]  b_wdata,
  output logic [LANE_W*LANES-1:0]  a_rdata,
  output logic [LANE_W*LANES-1:0]  b_rdata
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [MEM_AW-1:0] a_row;
  logic [MEM_AW-1:0] b_row;

  assign a_row = MEM_AW'(a_addr);
  assign b_row = MEM_AW'(b_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    // B is written first so that A's assignment lands last and wins
    always_ff @(posedge clk) begin
      if (b_we[l]) cells[b_row] <= b_wdata[l*LANE_W +: LANE_W];
      if (a_we[l]) cells[a_row] <= a_wdata[l*LANE_W +: LANE_W];
    end

    assign a_rdata[l*LANE_W +: LANE_W] = cells[a_row];
    assign b_rdata[l*LANE_W +: LANE_W] = cells[b_row];
  end

endmodule

// File: rtl/tpbr_out_stage.sv
module tpbr_out_stage #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_q,
  input  logic              ft_valid,
  input  logic [WORD_W-1:0] ft_word,
  output logic              rvalid,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] ft_masked;
  logic              p_valid;
  logic [WORD_W-1:0] p_data;

  assign ft_masked = ft_valid ? ft_word : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_valid <= 1'b0;
      p_data  <= '0;
    end else begin
      p_valid <= ft_valid;
      p_data  <= ft_masked;
    end
  end

  assign rvalid = pipe_q ? p_valid : ft_valid;
  assign rdata  = pipe_q ? p_data  : ft_masked;

endmodule

// File: rtl/twin_port_burst_ram.sv
module twin_port_burst_ram #(
  parameter int ADDR_W = 8,
  parameter int MEM_AW = 7,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n_a,
  input  logic                     cs_a,
  input  logic                     rw_a,
  input  logic [LANES-1:0]         lane_we_a,
  input  logic                     oe_a,
  input  logic                     pipe_a,
  input  logic [ADDR_W-1:0]        addr_a,
  input  logic                     ld_a,
  input  logic                     inc_a,
  input  logic                     clr_a,
  input  logic [LANE_W*LANES-1:0]  wdata_a,
  output logic                     rvalid_a,
  output logic [LANE_W*LANES-1:0]  rdata_a,
  input  logic                     cs_n_b,
  input  logic                     cs_b,
  input  logic                     rw_b,
  input  logic [LANES-1:0]         lane_we_b,
  input  logic                     oe_b,
  input  logic                     pipe_b,
  input  logic [ADDR_W-1:0]        addr_b,
  input  logic                     ld_b,
  input  logic                     inc_b,
  input  logic                     clr_b,
  input  logic [LANE_W*LANES-1:0]  wdata_b,
  output logic                     rvalid_b,
  output logic [LANE_W*LANES-1:0]  rdata_b
);

  localparam int WORD_W = LANE_W * LANES;

  logic              sel_in_a, sel_in_b;
  logic [ADDR_W-1:0] cnt_a, cnt_b;
  logic              sel_q_a, sel_q_b, rd_q_a, rd_q_b, oe_q_a, oe_q_b;
  logic              pipe_q_a, pipe_q_b;
  logic [LANES-1:0]  we_q_a, we_q_b;
  logic [WORD_W-1:0] wd_q_a, wd_q_b, arr_a, arr_b;
  logic              ft_valid_a, ft_valid_b;

  assign sel_in_a = !cs_n_a && cs_a;
  assign sel_in_b = !cs_n_b && cs_b;

  tpbr_port_front #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_front_a (
    .clk(clk), .rst_n(rst_n), .sel_in(sel_in_a), .rw(rw_a), .lane_we(lane_we_a),
    .oe(oe_a), .pipe(pipe_a), .addr(addr_a), .ld(ld_a), .inc(inc_a), .clr(clr_a),
    .wdata(wdata_a), .cnt(cnt_a), .sel_q(sel_q_a), .rd_q(rd_q_a), .oe_q(oe_q_a),
    .pipe_q(pipe_q_a), .we_q(we_q_a), .wdata_q(wd_q_a)
  );

  tpbr_port_front #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_front_b (
    .clk(clk), .rst_n(rst_n), .sel_in(sel_in_b), .rw(rw_b), .lane_we(lane_we_b),
    .oe(oe_b), .pipe(pipe_b), .addr(addr_b), .ld(ld_b), .inc(inc_b), .clr(clr_b),
    .wdata(wdata_b), .cnt(cnt_b), .sel_q(sel_q_b), .rd_q(rd_q_b), .oe_q(oe_q_b),
    .pipe_q(pipe_q_b), .we_q(we_q_b), .wdata_q(wd_q_b)
  );

  tpbr_array #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk),
    .a_addr(cnt_a), .a_we(we_q_a), .a_wdata(wd_q_a),
    .b_addr(cnt_b), .b_we(we_q_b), .b_wdata(wd_q_b),
    .a_rdata(arr_a), .b_rdata(arr_b)
  );

  assign ft_valid_a = sel_q_a && rd_q_a && oe_q_a;
  assign ft_valid_b = sel_q_b && rd_q_b && oe_q_b;

  tpbr_out_stage #(.WORD_W(WORD_W)) u_out_a (
    .clk(clk), .rst_n(rst_n), .pipe_q(pipe_q_a), .ft_valid(ft_valid_a),
    .ft_word(arr_a), .rvalid(rvalid_a), .rdata(rdata_a)
  );

  tpbr_out_stage #(.WORD_W(WORD_W)) u_out_b (
    .clk(clk), .rst_n(rst_n), .pipe_q(pipe_q_b), .ft_valid(ft_valid_b),
    .ft_word(arr_b), .rvalid(rvalid_b), .rdata(rdata_b)
  );

endmodule

// File: rtl/tpbr_checker.sv
module tpbr_checker #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_a,
  input logic              ld_a,
  input logic              inc_a,
  input logic [ADDR_W-1:0] addr_a,
  input logic              sel_in_a,
  input logic [ADDR_W-1:0] cnt_a,
  input logic              sel_q_a,
  input logic              pipe_q_a,
  input logic              ft_valid_a,
  input logic              rvalid_a,
  input logic [WORD_W-1:0] rdata_a,
  input logic              rvalid_b,
  input logic [WORD_W-1:0] rdata_b
);

  p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_a |=> cnt_a == '0);

  p_load_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_a && ld_a && sel_in_a) |=> cnt_a == $past(addr_a));

  p_step_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_a && !ld_a && inc_a && sel_in_a) |=> cnt_a == ADDR_W'($past(cnt_a) + 1'b1));

  p_desel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_a && !sel_in_a) |=> $stable(cnt_a));

  p_desel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_q_a && !sel_q_a) |-> !rvalid_a);

  p_pipe_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_q_a && ft_valid_a) |=> (!pipe_q_a || rvalid_a));

  p_blank_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_a |-> rdata_a == '0);

  p_blank_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_b |-> rdata_b == '0);

endmodule

bind twin_port_burst_ram tpbr_checker #(.ADDR_W(ADDR_W), .WORD_W(LANE_W*LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_a(clr_a), .ld_a(ld_a), .inc_a(inc_a),
  .addr_a(addr_a), .sel_in_a(sel_in_a), .cnt_a(cnt_a), .sel_q_a(sel_q_a),
  .pipe_q_a(pipe_q_a), .ft_valid_a(ft_valid_a), .rvalid_a(rvalid_a),
  .rdata_a(rdata_a), .rvalid_b(rvalid_b), .rdata_b(rdata_b)
);

// File: tb/twin_port_burst_ram_tb.sv
`timescale 1ns/1ps
module twin_port_burst_ram_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic       cs_n [2], cs [2], rw [2], oe [2], pipe [2], ld [2], inc [2], clr [2];
  logic [1:0] lwe [2];
  logic [7:0] addr [2];
  logic [17:0] wd [2];
  logic       rv [2];
  logic [17:0] rd [2];

  int ck = 0;
  int fails = 0;
  string phase = "R1 reset";

  always #4 clk = ~clk;

  twin_port_burst_ram u_dut (
    .clk(clk), .rst_n(rst_n),
    .cs_n_a(cs_n[0]), .cs_a(cs[0]), .rw_a(rw[0]), .lane_we_a(lwe[0]), .oe_a(oe[0]),
    .pipe_a(pipe[0]), .addr_a(addr[0]), .ld_a(ld[0]), .inc_a(inc[0]), .clr_a(clr[0]),
    .wdata_a(wd[0]), .rvalid_a(rv[0]), .rdata_a(rd[0]),
    .cs_n_b(cs_n[1]), .cs_b(cs[1]), .rw_b(rw[1]), .lane_we_b(lwe[1]), .oe_b(oe[1]),
    .pipe_b(pipe[1]), .addr_b(addr[1]), .ld_b(ld[1]), .inc_b(inc[1]), .clr_b(clr[1]),
    .wdata_b(wd[1]), .rvalid_b(rv[1]), .rdata_b(rd[1])
  );

  // behavioural reference
  bit [17:0] mw [int];
  bit [1:0]  mk [int];
  int        m_cnt [2];
  bit        m_sel [2], m_rd [2], m_oe [2], m_pipe [2], m_pv [2], m_pk [2];
  bit [1:0]  m_we [2];
  bit [17:0] m_wd [2], m_pd [2];

  function automatic logic [17:0] dA(int i); return 18'(i * 613 + 5); endfunction
  function automatic logic [17:0] dB(int i); return 18'(i * 911 + 77); endfunction

  function automatic void ft_model(int p, output bit v, output bit [17:0] d, output bit k);
    int i;
    i = m_cnt[p] & 127;
    v = m_sel[p] && m_rd[p] && m_oe[p];
    d = '0;
    k = 1'b1;
    if (v) begin
      if (mk.exists(i) && mk[i] == 2'b11) d = mw[i];
      else k = 1'b0;
    end
  endfunction

  always @(posedge clk) begin
    bit nv [2];
    bit [17:0] nd [2];
    bit nk [2];
    bit s;
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_cnt[p] = 0; m_sel[p] = 0; m_rd[p] = 0; m_oe[p] = 0; m_pipe[p] = 0;
        m_we[p] = 0; m_wd[p] = 0; m_pv[p] = 0; m_pd[p] = 0; m_pk[p] = 1;
      end
    end else begin
      for (int p = 0; p < 2; p++) ft_model(p, nv[p], nd[p], nk[p]);
      for (int p = 1; p >= 0; p--) begin
        for (int l = 0; l < 2; l++) begin
          if (m_we[p][l]) begin
            int i;
            i = m_cnt[p] & 127;
            if (!mk.exists(i)) begin mk[i] = 0; mw[i] = 0; end
            mw[i][l*9 +: 9] = m_wd[p][l*9 +: 9];
            mk[i][l] = 1'b1;
          end
        end
      end
      for (int p = 0; p < 2; p++) begin
        m_pv[p] = nv[p]; m_pd[p] = nd[p]; m_pk[p] = nk[p];
        s = !cs_n[p] && cs[p];
        if (clr[p]) m_cnt[p] = 0;
        else if (s && ld[p]) m_cnt[p] = int'(addr[p]);
        else if (s && inc[p]) m_cnt[p] = (m_cnt[p] + 1) & 255;
        m_sel[p] = s; m_rd[p] = rw[p]; m_oe[p] = oe[p]; m_pipe[p] = pipe[p];
        m_we[p] = (s && !rw[p]) ? lwe[p] : 2'b00;
        m_wd[p] = wd[p];
      end
    end
  end

  task automatic compare_all();
    for (int p = 0; p < 2; p++) begin
      bit ev; bit [17:0] ed; bit ek;
      if (m_pipe[p]) begin ev = m_pv[p]; ed = m_pd[p]; ek = m_pk[p]; end
      else ft_model(p, ev, ed, ek);
      ck++;
      if (rv[p] !== ev || (ek && rd[p] !== ed)) begin
        fails++;
        $display("FAIL %s port %0d: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                 phase, p, rv[p], rd[p], ev, ed);
      end
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    ck++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_all();
    for (int p = 0; p < 2; p++) begin
      cs_n[p] = 0; cs[p] = 0; rw[p] = 1; lwe[p] = 0; oe[p] = 1;
      ld[p] = 0; inc[p] = 0; clr[p] = 0; addr[p] = 0; wd[p] = 0;
    end
  endtask

  task automatic selp(int p);
    cs_n[p] = 0; cs[p] = 1;
  endtask

  task automatic wr(int p, int a, bit [1:0] lanes, bit [17:0] data);
    selp(p); ld[p] = 1; addr[p] = 8'(a); rw[p] = 0; lwe[p] = lanes; wd[p] = data;
  endtask

  task automatic rdq(int p, int a);
    selp(p); ld[p] = 1; addr[p] = 8'(a); rw[p] = 1; oe[p] = 1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", ck, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R11: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    idle_all();
    pipe[0] = 0; pipe[1] = 0;
    @(negedge clk);
    repeat (3) tick();
    chk("R1 rvalid a in reset", 32'(rv[0]), 0);
    chk("R1 rdata a in reset", 32'(rd[0]), 0);
    chk("R1 rvalid b in reset", 32'(rv[1]), 0);
    rst_n = 1;
    tick();
    chk("R1 rdata b after reset", 32'(rd[1]), 0);

    // R11: both ports fill blocks at once through the burst counter
    phase = "R11 concurrent fill";
    for (int i = 0; i < 32; i++) begin
      idle_all();
      wr(0, i, 2'b11, dA(i));
      wr(1, 64 + i, 2'b11, dB(i));
      if (i > 0) begin ld[0] = 0; ld[1] = 0; inc[0] = 1; inc[1] = 1; end
      tick();
    end

    // R6: A flow-through, B pipelined
    phase = "R6 latency";
    idle_all(); pipe[0] = 0; pipe[1] = 1; tick();
    rdq(0, 3); rdq(1, 67); tick();
    chk("R6 flow a valid", 32'(rv[0]), 1);
    chk("R6 flow a data", 32'(rd[0]), 32'(dA(3)));
    chk("R6 pipe b not yet", 32'(rv[1]), 0);
    idle_all(); tick();
    chk("R6 pipe b valid", 32'(rv[1]), 1);
    chk("R6 pipe b data", 32'(rd[1]), 32'(dB(3)));
    chk("R6 flow a finished", 32'(rv[0]), 0);
    phase = "R11 R6 burst reads";
    for (int i = 0; i < 32; i++) begin
      idle_all(); rdq(0, 0); rdq(1, 64);
      if (i > 0) begin ld[0] = 0; ld[1] = 0; inc[0] = 1; inc[1] = 1; end
      tick();
    end
    idle_all(); tick(); tick();

    // R4: lane enables
    phase = "R4 lanes";
    wr(0, 10, 2'b01, 18'h3FFFF); tick();
    idle_all(); rdq(0, 10); tick();
    begin
      logic [17:0] o;
      o = dA(10);
      chk("R4 low lane only", 32'(rd[0]), 32'({o[17:9], 9'h1FF}));
    end
    idle_all(); wr(0, 10, 2'b10, 18'h0); tick();
    idle_all(); rdq(0, 10); tick();
    chk("R4 high lane only", 32'(rd[0]), 32'h001FF);

    // R5: deselection
    phase = "R5 deselect";
    idle_all();
    cs_n[0] = 1; cs[0] = 1; rw[0] = 0; lwe[0] = 3; ld[0] = 1; addr[0] = 11; wd[0] = 0;
    tick();
    chk("R5 no valid when cs_n high", 32'(rv[0]), 0);
    idle_all();
    cs_n[0] = 0; cs[0] = 0; rw[0] = 0; lwe[0] = 3; ld[0] = 1; addr[0] = 11; inc[0] = 1;
    tick();
    idle_all(); selp(0); tick();
    chk("R5 counter kept", 32'(rd[0]), 32'h001FF);
    idle_all(); rdq(0, 11); tick();
    chk("R5 no write when deselected", 32'(rd[0]), 32'(dA(11)));
    idle_all(); clr[0] = 1; tick();
    idle_all(); selp(0); tick();
    chk("R5 clear while deselected", 32'(rd[0]), 32'(dA(0)));

    // R7: operation select and output enable
    phase = "R7 oe and rw";
    idle_all(); rdq(0, 1); oe[0] = 0; tick();
    chk("R7 oe low valid", 32'(rv[0]), 0);
    chk("R7 oe low data", 32'(rd[0]), 0);
    idle_all(); wr(0, 12, 2'b11, dA(12)); tick();
    chk("R7 write gives no valid", 32'(rv[0]), 0);

    // R8: write-write collision
    phase = "R8 write collision";
    idle_all(); wr(0, 20, 2'b11, 18'h15555); wr(1, 20, 2'b11, 18'h2AAAA); tick();
    idle_all(); rdq(0, 20); tick();
    chk("R8 port A wins", 32'(rd[0]), 32'h15555);
    idle_all(); wr(0, 21, 2'b01, 18'h000AB); wr(1, 21, 2'b10, 18'h3FE00); tick();
    idle_all(); rdq(1, 21); tick();
    idle_all(); tick();
    chk("R8 split lanes merge", 32'(rd[1]), 32'h3FEAB);

    // R9: read-write collision, both latency modes
    phase = "R9 read collision";
    idle_all(); wr(0, 5, 2'b11, 18'h0F0F0); rdq(1, 5); tick();
    idle_all(); tick();
    chk("R9 old data pipelined", 32'(rd[1]), 32'(dA(5)));
    idle_all(); rdq(1, 5); tick();
    idle_all(); tick();
    chk("R9 new data pipelined", 32'(rd[1]), 32'h0F0F0);
    idle_all(); wr(1, 6, 2'b11, 18'h00F0F); rdq(0, 6); tick();
    chk("R9 old data flow", 32'(rd[0]), 32'(dA(6)));
    idle_all(); rdq(0, 6); tick();
    chk("R9 new data flow", 32'(rd[0]), 32'h00F0F);

    // R10: upper address bit ignored
    phase = "R10 alias";
    idle_all(); wr(0, 8'h85, 2'b11, 18'h2468A); tick();
    idle_all(); rdq(1, 8'h05); tick();
    idle_all(); tick();
    chk("R10 aliased word", 32'(rd[1]), 32'h2468A);

    // R2: counter priority on port A (flow-through)
    phase = "R2 priority";
    idle_all(); rdq(0, 9); clr[0] = 1; inc[0] = 1; tick();
    chk("R2 clear beats load", 32'(rd[0]), 32'(dA(0)));
    idle_all(); rdq(0, 9); inc[0] = 1; tick();
    chk("R2 load beats step", 32'(rd[0]), 32'(dA(9)));
    idle_all(); selp(0); inc[0] = 1; tick();
    chk("R2 step", 32'(rd[0]), 32'h001FF);
    idle_all(); selp(0); tick();
    chk("R2 hold", 32'(rd[0]), 32'h001FF);

    // R3: wrap
    phase = "R3 wrap";
    idle_all(); wr(0, 8'hFF, 2'b11, 18'h13579); tick();
    idle_all(); rdq(0, 8'hFF); tick();
    chk("R3 top word", 32'(rd[0]), 32'h13579);
    idle_all(); selp(0); inc[0] = 1; tick();
    chk("R3 wrap to zero", 32'(rd[0]), 32'(dA(0)));

    // random mix provoking collisions on a few words
    phase = "R11 R9 R8 random mix";
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < 2; p++) begin
        cs_n[p] = ($urandom % 4) == 0;
        cs[p]   = ($urandom % 5) != 0;
        rw[p]   = $urandom % 2;
        lwe[p]  = 2'($urandom % 4);
        oe[p]   = ($urandom % 5) != 0;
        if (($urandom % 16) == 0) pipe[p] = ~pipe[p];
        ld[p]   = ($urandom % 3) == 0;
        inc[p]  = $urandom % 2;
        clr[p]  = ($urandom % 20) == 0;
        addr[p] = 8'((($urandom % 2) << 7) | ($urandom % 8));
        wd[p]   = 18'($urandom);
      end
      tick();
    end
    idle_all();
    repeat (3) tick();

    summary();
    $finish;
  end

endmodule